// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer Unit

This block collects up to three down-counting timer channels behind one 4 KB register window on a simple word-wide read/write bus. A shared start register carries one run bit per channel, so software can start or stop each channel on its own while the others keep counting. Each channel counts down from a programmable value at a divided clock rate. When it steps past zero it reloads from its constant register and raises an underflow flag. That flag drives the channel's own interrupt line when the channel's interrupt enable is set.

Two build options shape the unit. One adds the third channel, which is the only channel with a capture register. The other adds a one-bit output-control register at the bottom of the window. An access that needs a missing option is rejected. It raises a one-cycle error pulse and changes nothing else. Reads of offsets that map to no register return zero and do not raise the error.

Top module: `tmu_unit`

## Requirements
- R1: After reset the start register, output-control bit, control registers and capture register read zero. Every counter and reload register reads all ones, and all interrupt and error outputs are low.
- R2: Addresses are decoded on word index `addr[11:2]`, and the larger index wins: index 8 and up selects channel 2 (relative word = index-8), 5..7 selects channel 1 (index-5), 2..4 selects channel 0 (index-2), 1 selects the start register and 0 the output-control register. The relative words are 0 reload, 1 counter, 2 control and 3 capture.
- R3: Start-register bits 0, 1 and 2 run channels 0, 1 and 2. A cleared bit freezes that channel's counter at its present value, and setting the bit again resumes counting from that value.
- R4: Control bits [2:0] choose the count rate. A running channel decrements once every 4^(code+1) clocks for codes 0..4, and once every 1024 clocks for codes 5..7. A write to the channel's counter or control register restarts the divider from zero.
- R5: When a counting step finds the counter at zero, the counter loads the reload value and the underflow flag (control bit 8) is set.
- R6: A channel's interrupt output equals its underflow flag AND its enable bit (control bit 5). A control write with bit 8 at 0 clears the flag, and with bit 8 at 1 leaves it unchanged. An underflow in the same cycle as a clearing write wins.
- R7: A bus write to a counter takes effect in place of any counting step in that cycle.
- R8: With the output-control option, offset 0x00 stores only bit 0 of write data and reads it back in bit 0. Without the option, any access to offset 0x00 is illegal.
- R9: Without the three-channel option, any access at index 8 and up is illegal, and so is a start write with bit 2 set. The start register then keeps its old value.
- R10: An illegal access raises `err_o` for exactly the following cycle, returns read data zero and changes no register.
- R11: A mapped but unused offset inside channel 2's range (relative word 4 and up) reads zero, ignores writes and raises no error.
- R12: Only channel 2 has a capture register, a 32-bit read/write store. The start register stores all 32 written bits and reads them back.
- R13: Read data appears on `bus_rdata` in the cycle after `bus_rd`, holding the register value from before that clock edge. It is zero in cycles after no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 3 | Per-channel interrupt lines |
| err_o | output | 1 | One-cycle pulse after an illegal access |

## Verification
The bench builds two copies on the same bus. One has the default parameters, with both the third channel and the output-control register present. The other has both options turned off. The full build brings the capture register, channel 2 counting and the unused offsets above it within reach. The reduced build makes every illegal-access path reachable: output-control accesses, channel 2 accesses and a start write with bit 2 set. Identical stimulus can then be compared across the two builds.

// File: rtl/tmu_pkg.sv
package tmu_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int NCH    = 3;
  localparam int PRE_W  = 10;

  typedef struct packed {
    logic             hit_ocr;
    logic             hit_start;
    logic [NCH-1:0]   hit_ch;
    logic [1:0]       reg_sel;
    logic             illegal;
  } dec_t;

  // divider length for a rate code: 4^(code+1), codes above 4 saturate at 1024
  function automatic logic [PRE_W:0] prescale_div(input logic [2:0] code);
    logic [2:0] c;
    c = (code > 3'd4) ? 3'd4 : code;
    return (PRE_W+1)'(1) << (2 * c + 2);
  endfunction
endpackage

// File: rtl/tmu_addr_decode.sv
module tmu_addr_decode
  import tmu_pkg::*;
#(
  parameter bit HAS_CH2 = 1'b1,
  parameter bit HAS_OCR = 1'b1
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              wbit2_i,
  output dec_t              dec_o
);
  localparam int WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] widx;
  logic [WIDX_W-1:0] rel;

  assign widx = addr_i[ADDR_W-1:2];

  always_comb begin
    dec_o = '0;
    rel   = '0;
    if (widx >= WIDX_W'(8)) begin
      rel = widx - WIDX_W'(8);
      if (!HAS_CH2) dec_o.illegal = 1'b1;
      else if (rel < WIDX_W'(4)) begin
        dec_o.hit_ch[2] = 1'b1;
        dec_o.reg_sel   = rel[1:0];
      end
    end else if (widx >= WIDX_W'(5)) begin
      rel = widx - WIDX_W'(5);
      dec_o.hit_ch[1] = 1'b1;
      dec_o.reg_sel   = rel[1:0];
    end else if (widx >= WIDX_W'(2)) begin
      rel = widx - WIDX_W'(2);
      dec_o.hit_ch[0] = 1'b1;
      dec_o.reg_sel   = rel[1:0];
    end else if (widx == WIDX_W'(1)) begin
      dec_o.hit_start = 1'b1;
      if (!HAS_CH2 && wr_i && wbit2_i) dec_o.illegal = 1'b1;
    end else begin
      if (HAS_OCR) dec_o.hit_ocr = 1'b1;
      else         dec_o.illegal = 1'b1;
    end
  end
endmodule

// File: rtl/tmu_prescaler.sv
module tmu_prescaler
  import tmu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_i,
  input  logic       restart_i,
  input  logic [2:0] code_i,
  output logic       tick_o
);
  logic [PRE_W:0]   div;
  logic [PRE_W-1:0] last;
  logic [PRE_W-1:0] pre_q;

  assign div    = prescale_div(code_i);
  assign last   = PRE_W'(div - 1'b1);
  assign tick_o = run_i && !restart_i && (pre_q == last);

  always_ff @(posedge clk) begin
    if (!rst_n)                    pre_q <= '0;
    else if (!run_i || restart_i)  pre_q <= '0;
    else if (pre_q == last)        pre_q <= '0;
    else                           pre_q <= pre_q + 1'b1;
  end

  AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q <= last); // R4
endmodule

// File: rtl/tmu_channel.sv
module tmu_channel
  import tmu_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter bit HAS_CAP = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             wr_reload_i,
  input  logic             wr_count_i,
  input  logic             wr_ctrl_i,
  input  logic             wr_cap_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic [1:0]       rd_sel_i,
  output logic [CNT_W-1:0] rd_data_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] reload_q, cnt_q, cap_q, ctl_word;
  logic [2:0]       psc_q;
  logic             ie_q, flag_q;
  logic             tick, underflow;

  tmu_prescaler u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (run_i),
    .restart_i(wr_count_i || wr_ctrl_i),
    .code_i   (psc_q),
    .tick_o   (tick)
  );

  assign underflow = tick && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_q <= '1;
      cnt_q    <= '1;
      psc_q    <= '0;
      ie_q     <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      if (wr_reload_i) reload_q <= wdata_i;
      if (wr_count_i)  cnt_q <= wdata_i;
      else if (tick)   cnt_q <= underflow ? reload_q : cnt_q - 1'b1;
      if (underflow)                    flag_q <= 1'b1;
      else if (wr_ctrl_i && !wdata_i[8]) flag_q <= 1'b0;
      if (wr_ctrl_i) begin
        psc_q <= wdata_i[2:0];
        ie_q  <= wdata_i[5];
      end
    end
  end

  generate
    if (HAS_CAP) begin : g_cap
      always_ff @(posedge clk) begin
        if (!rst_n)        cap_q <= '0;
        else if (wr_cap_i) cap_q <= wdata_i;
      end
    end else begin : g_nocap
      assign cap_q = '0;
    end
  endgenerate

  always_comb begin
    ctl_word      = '0;
    ctl_word[8]   = flag_q;
    ctl_word[5]   = ie_q;
    ctl_word[2:0] = psc_q;
    case (rd_sel_i)
      2'd0:    rd_data_o = reload_q;
      2'd1:    rd_data_o = cnt_q;
      2'd2:    rd_data_o = ctl_word;
      default: rd_data_o = cap_q;
    endcase
  end

  assign irq_o = flag_q && ie_q;

  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !wr_count_i) |=> $stable(cnt_q)); // R3
  AST_UNDERFLOW_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> (flag_q && cnt_q == $past(reload_q))); // R5
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl_i && !wdata_i[8] && !underflow) |=> !flag_q); // R6
  AST_COUNT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_count_i |=> cnt_q == $past(wdata_i)); // R7
endmodule

// File: rtl/tmu_unit.sv
module tmu_unit
  import tmu_pkg::*;
#(
  parameter bit HAS_CH2 = 1'b1,
  parameter bit HAS_OCR = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NCH-1:0]    irq_o,
  output logic              err_o
);
  dec_t              dec;
  logic              acc, bad, wr_ok;
  logic [DATA_W-1:0] start_q, rd_val;
  logic              ocr_q;
  logic [DATA_W-1:0] ch_rd [NCH];

  assign acc   = bus_rd || bus_wr;
  assign bad   = acc && dec.illegal;
  assign wr_ok = bus_wr && !dec.illegal;

  tmu_addr_decode #(.HAS_CH2(HAS_CH2), .HAS_OCR(HAS_OCR)) u_dec (
    .addr_i (bus_addr),
    .wr_i   (bus_wr),
    .wbit2_i(bus_wdata[2]),
    .dec_o  (dec)
  );

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      if (i < 2 || HAS_CH2) begin : g_on
        tmu_channel #(.CNT_W(DATA_W), .HAS_CAP(i == 2)) u_ch (
          .clk        (clk),
          .rst_n      (rst_n),
          .run_i      (start_q[i]),
          .wr_reload_i(wr_ok && dec.hit_ch[i] && dec.reg_sel == 2'd0),
          .wr_count_i (wr_ok && dec.hit_ch[i] && dec.reg_sel == 2'd1),
          .wr_ctrl_i  (wr_ok && dec.hit_ch[i] && dec.reg_sel == 2'd2),
          .wr_cap_i   (wr_ok && dec.hit_ch[i] && dec.reg_sel == 2'd3),
          .wdata_i    (bus_wdata),
          .rd_sel_i   (dec.reg_sel),
          .rd_data_o  (ch_rd[i]),
          .irq_o      (irq_o[i])
        );
      end else begin : g_off
        assign ch_rd[i] = '0;
        assign irq_o[i] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    rd_val = '0;
    if (!dec.illegal) begin
      if (dec.hit_ocr)        rd_val = {{(DATA_W-1){1'b0}}, ocr_q};
      else if (dec.hit_start) rd_val = start_q;
      else
        for (int i = 0; i < NCH; i++)
          if (dec.hit_ch[i]) rd_val = ch_rd[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q   <= '0;
      ocr_q     <= 1'b0;
      bus_rdata <= '0;
      err_o     <= 1'b0;
    end else begin
      if (wr_ok && dec.hit_start) start_q <= bus_wdata;
      if (wr_ok && dec.hit_ocr)   ocr_q   <= bus_wdata[0];
      bus_rdata <= bus_rd ? rd_val : '0;
      err_o     <= bad;
    end
  end

  AST_DECODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dec.hit_ocr, dec.hit_start, dec.hit_ch})); // R2
  AST_ILLEGAL_KEEPS_START: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> $stable(start_q)); // R9
  AST_ILLEGAL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && dec.illegal) |=> (bus_rdata == '0 && err_o)); // R10
  AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> bus_rdata == '0); // R13
endmodule

// File: tb/tmu_unit_bench.sv
module tmu_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG       = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata [2];
  logic [2:0]  irq [2];
  logic        err [2];

  int n_chk = 0, n_fail = 0, cyc = 0;
  string cur_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  tmu_unit u_tmu_unit (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(rdata[0]), .irq_o(irq[0]), .err_o(err[0]));

  tmu_unit #(.HAS_CH2(1'b0), .HAS_OCR(1'b0)) u_tmu_unit_lite (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(rdata[1]), .irq_o(irq[1]), .err_o(err[1]));

  // behavioural reference state, index [build][channel]
  logic [31:0] m_reload [2][3], m_cnt [2][3];
  int          m_pre [2][3];
  logic [2:0]  m_psc [2][3];
  logic        m_ie [2][3], m_flag [2][3];
  logic [31:0] m_start [2], m_cap [2], m_rdata [2];
  logic        m_ocr [2], m_err [2];

  task automatic model_reset();
    for (int k = 0; k < 2; k++) begin
      for (int c = 0; c < 3; c++) begin
        m_reload[k][c] = '1; m_cnt[k][c] = '1; m_pre[k][c] = 0;
        m_psc[k][c] = '0; m_ie[k][c] = 0; m_flag[k][c] = 0;
      end
      m_start[k] = '0; m_cap[k] = '0; m_rdata[k] = '0; m_ocr[k] = 0; m_err[k] = 0;
    end
  endtask

  task automatic model_step(input int k);
    bit has2, hasocr, acc, ill, wok, mapped;
    int widx, ch, rel, div;
    logic [31:0] rv;
    has2 = (k == 0); hasocr = (k == 0);
    acc = bus_rd || bus_wr;
    widx = int'(bus_addr) / 4;
    ill = acc && ((widx >= 8 && !has2) || (widx == 0 && !hasocr) ||
                  (widx == 1 && bus_wr && bus_wdata[2] && !has2));
    ch = -1; rel = 0;
    if (widx >= 8) begin ch = 2; rel = widx - 8; end
    else if (widx >= 5) begin ch = 1; rel = widx - 5; end
    else if (widx >= 2) begin ch = 0; rel = widx - 2; end
    mapped = (ch >= 0) && rel < 4 && (ch < 2 || has2);
    rv = '0;
    if (!ill) begin
      if (widx == 0) rv = {31'b0, m_ocr[k]};
      else if (widx == 1) rv = m_start[k];
      else if (mapped) begin
        case (rel)
          0: rv = m_reload[k][ch];
          1: rv = m_cnt[k][ch];
          2: rv = (32'(m_flag[k][ch]) << 8) | (32'(m_ie[k][ch]) << 5) | 32'(m_psc[k][ch]);
          default: rv = (ch == 2) ? m_cap[k] : '0;
        endcase
      end
    end
    m_rdata[k] = bus_rd ? rv : '0;
    m_err[k] = ill;
    wok = bus_wr && !ill;
    for (int c = 0; c < 3; c++) begin
      bit run, wc, wctl, restart, tick, uf;
      if (c == 2 && !has2) continue;
      run = m_start[k][c];
      wc = wok && mapped && ch == c && rel == 1;
      wctl = wok && mapped && ch == c && rel == 2;
      div = (m_psc[k][c] > 4) ? 1024 : (1 << (2 * int'(m_psc[k][c]) + 2));
      restart = wc || wctl;
      tick = run && !restart && m_pre[k][c] == div - 1;
      if (!run || restart || m_pre[k][c] == div - 1) m_pre[k][c] = 0;
      else m_pre[k][c]++;
      uf = 0;
      if (wc) m_cnt[k][c] = bus_wdata;
      else if (tick) begin
        if (m_cnt[k][c] == 0) begin m_cnt[k][c] = m_reload[k][c]; uf = 1; end
        else m_cnt[k][c] = m_cnt[k][c] - 1;
      end
      if (uf) m_flag[k][c] = 1;
      else if (wctl && !bus_wdata[8]) m_flag[k][c] = 0;
      if (wctl) begin m_psc[k][c] = bus_wdata[2:0]; m_ie[k][c] = bus_wdata[5]; end
      if (wok && mapped && ch == c && rel == 0) m_reload[k][c] = bus_wdata;
      if (wok && mapped && ch == 2 && c == 2 && rel == 3) m_cap[k] = bus_wdata;
    end
    if (wok && widx == 1) m_start[k] = bus_wdata;
    if (wok && widx == 0) m_ocr[k] = bus_wdata[0];
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else for (int k = 0; k < 2; k++) model_step(k);
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      for (int k = 0; k < 2; k++) begin
        logic [2:0] ei;
        for (int c = 0; c < 3; c++) ei[c] = m_flag[k][c] && m_ie[k][c] && (c < 2 || k == 0);
        chk({cur_tag, "/R13"}, k == 0 ? "rdata full" : "rdata lite", rdata[k], m_rdata[k]);
        chk({cur_tag, "/R6"}, k == 0 ? "irq full" : "irq lite", 32'(irq[k]), 32'(ei));
        chk({cur_tag, "/R10"}, k == 0 ? "err full" : "err lite", 32'(err[k]), 32'(m_err[k]));
      end
    end
    if (cyc == WDOG) begin
      n_fail++;
      $display("FAIL R13 watchdog actual=%0d expected<%0d", cyc, WDOG);
      finish_run();
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  // read with explicit expected values for the full and the reduced build
  task automatic rd_exp(input logic [11:0] a, input string tag,
                        input logic [31:0] e0, input logic [31:0] e1, input bit use_e1);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    chk(tag, "read full", rdata[0], e0);
    if (use_e1) chk(tag, "read lite", rdata[1], e1);
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    chk(tag, "read full vs model", rdata[0], m_rdata[0]);
    chk(tag, "read lite vs model", rdata[1], m_rdata[1]);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cur_tag = "R1";
    rd_exp(12'h004, "R1", 32'h0, 32'h0, 1);
    rd_exp(12'h00C, "R1", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1);
    rd_exp(12'h01C, "R1", 32'h0, 32'h0, 1);
    chk("R1", "irq full", 32'(irq[0]), 32'h0);

    cur_tag = "R2";
    wr(12'h008, 32'd5); wr(12'h014, 32'd9);
    rd_exp(12'h008, "R2", 32'd5, 32'd5, 1);
    rd_exp(12'h014, "R2", 32'd9, 32'd9, 1);

    cur_tag = "R5";
    wr(12'h00C, 32'd3); wr(12'h010, 32'h20);
    wr(12'h004, 32'h1);
    idle(30);
    rd(12'h00C, "R5");
    rd_exp(12'h010, "R6", 32'h120, 32'h120, 1);
    cur_tag = "R6";
    chk("R6", "irq ch0 set", 32'(irq[0][0]), 32'h1);
    wr(12'h010, 32'h120);
    chk("R6", "flag kept", 32'(irq[0][0]), 32'h1);
    wr(12'h010, 32'h020);
    chk("R6", "flag cleared", 32'(irq[0][0]), 32'h0);

    cur_tag = "R3";
    wr(12'h004, 32'h0);
    rd(12'h00C, "R3");
    idle(40);
    rd(12'h00C, "R3");
    wr(12'h004, 32'h1);
    idle(20);
    rd(12'h00C, "R3");

    cur_tag = "R7";
    wr(12'h00C, 32'd2);
    rd(12'h00C, "R7");

    cur_tag = "R4";
    wr(12'h018, 32'd2); wr(12'h01C, 32'h22);
    wr(12'h004, 32'h3);
    idle(130);
    rd(12'h018, "R4");
    idle(100);
    rd(12'h018, "R4");
    wr(12'h01C, 32'h27);
    wr(12'h018, 32'd1);
    idle(2100);
    rd(12'h018, "R4");
    rd(12'h01C, "R4");

    cur_tag = "R12";
    wr(12'h02C, 32'hCAFE_0123);
    rd_exp(12'h02C, "R12", 32'hCAFE_0123, 32'h0, 1);
    wr(12'h004, 32'h8000_0003);
    rd_exp(12'h004, "R12", 32'h8000_0003, 32'h8000_0003, 1);

    cur_tag = "R9";
    wr(12'h024, 32'd4); wr(12'h028, 32'h20);
    wr(12'h004, 32'h7);
    chk("R9", "err lite", 32'(err[1]), 32'h1);
    chk("R9", "err full", 32'(err[0]), 32'h0);
    rd_exp(12'h004, "R9", 32'h7, 32'h8000_0003, 1);
    idle(40);
    rd(12'h024, "R9");
    rd(12'h020, "R9");

    cur_tag = "R8";
    wr(12'h000, 32'hFFFF_FFFE);
    rd_exp(12'h000, "R8", 32'h0, 32'h0, 1);
    wr(12'h000, 32'h0000_0003);
    chk("R8", "err lite", 32'(err[1]), 32'h1);
    rd_exp(12'h000, "R8", 32'h1, 32'h0, 1);

    cur_tag = "R11";
    wr(12'h030, 32'h1234);
    chk("R11", "no err full", 32'(err[0]), 32'h0);
    rd_exp(12'h030, "R11", 32'h0, 32'h0, 1);
    chk("R10", "err pulse lite", 32'(err[1]), 32'h1);
    @(negedge clk);
    chk("R10", "err one cycle", 32'(err[1]), 32'h0);

    cur_tag = "R13";
    idle(20);
    rd(12'h00C, "R13");
    finish_run();
  end
endmodule